// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This peripheral keeps a 32-bit count of elapsed seconds. A prescaler counts reference clock cycles against a programmable rate word, which holds the reference frequency in Hz. Once per second it emits a single-cycle tick that advances the count. Software reaches the block through a 16-bit register bus. Each 32-bit quantity occupies two word-aligned registers, with the low half at the lower offset.

Setting a time and sampling the running count both use self-clearing request bits in the control register. Software sets the bit and polls until the hardware has cleared it. A 32-bit match register raises a sticky alarm. That alarm drives an interrupt output which software can mask, force or clear. A synchronous soft reset, held through a control bit, returns the time-keeping state to zero and keeps the programmed registers.

Top module: `rtc_sec_timer`

## Requirements
- R1: After rst_ni the control register reads 0x0021 (soft reset released, interrupt masked), every other register reads 0 and irq_o is 0.
- R2: The word index (byte offset / 4) selects the register: 0 control, 1/2 rate low/high, 3/4 preset low/high, 5/6 match low/high, 7 status, 8/9 captured count low/high. Rate, preset and match read back what was written. Writes to status and to the captured count are ignored. Indices 10 to 15 read 0.
- R3: Control bit1 enables counting. With rate word F ≥ 1 the count rises by one every F clock cycles, and the first increment lands on the F-th edge after the enabling write edge. With F = 0 the count never advances.
- R4: While bit1 is 0 the count holds and the prescaler returns to zero, so a re-enabled run again waits a full F cycles.
- R5: Writing control bit3 copies the preset into the count on the next edge, and the hardware clears bit3 on that same edge.
- R6: Writing control bit4 stores the count into the captured-count registers on the next edge, and the hardware clears bit4 on that edge.
- R7: When a tick arrives at 0xFFFFFFFF the count becomes 0 if control bit2 (wrap) is 1 and stays at 0xFFFFFFFF otherwise.
- R8: Status bit0 (raw alarm) is set on the edge where a tick or a preset copy gives the count a value equal to the match register. It then stays set.
- R9: Status bit1 and irq_o equal (raw alarm AND NOT control bit5 mask) OR control bit6 force.
- R10: Control bit7 clears the raw alarm on the next edge and then clears itself. If a new match occurs on the same edge, the new match wins.
- R11: While control bit0 is 0 the count, the prescaler and the raw alarm are held at zero. The rate, preset and match registers keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock, also the bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_i | input | 1 | Write strobe for the addressed register |
| addr_i | input | 4 | Word index (byte offset bits 5:2) |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register, combinational |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The bench uses the default 16-bit data width, so the count is a full 32 bits. It programs rate words of 4 and 0, which makes a simulated second last four clock cycles. Presets just below 0xFFFFFFFF then reach both the wrap and the saturate behaviour within a few ticks. A behavioural model predicts the read data and irq_o on every cycle. Hand-computed values pin the edge on which each tick, preset copy, capture and alarm clear takes effect.

// File: rtl/rtc_sec_pkg.sv
`timescale 1ns/1ps
package rtc_sec_pkg;
  localparam int unsigned IDX_W = 4;

  localparam logic [IDX_W-1:0] IDX_CTRL     = 4'd0;
  localparam logic [IDX_W-1:0] IDX_RATE_LO  = 4'd1;
  localparam logic [IDX_W-1:0] IDX_RATE_HI  = 4'd2;
  localparam logic [IDX_W-1:0] IDX_PRE_LO   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_PRE_HI   = 4'd4;
  localparam logic [IDX_W-1:0] IDX_MATCH_LO = 4'd5;
  localparam logic [IDX_W-1:0] IDX_MATCH_HI = 4'd6;
  localparam logic [IDX_W-1:0] IDX_STAT     = 4'd7;
  localparam logic [IDX_W-1:0] IDX_CAP_LO   = 4'd8;
  localparam logic [IDX_W-1:0] IDX_CAP_HI   = 4'd9;

  // writable 32-bit pairs: 0 rate, 1 preset, 2 match; low half at index 1+2g
  localparam int unsigned NUM_PAIR = 3;
  localparam int unsigned STAT_W   = 2;

  typedef struct packed {
    logic clr;
    logic frc;
    logic mask;
    logic cap;
    logic load;
    logic wrap;
    logic cnt_en;
    logic srst_n;
  } ctrl_t;

  localparam int unsigned CTRL_W = $bits(ctrl_t);
  localparam ctrl_t CTRL_RST = '{clr: 1'b0, frc: 1'b0, mask: 1'b1, cap: 1'b0,
                                 load: 1'b0, wrap: 1'b0, cnt_en: 1'b0, srst_n: 1'b1};
endpackage

// File: rtl/rtc_sec_regs.sv
`timescale 1ns/1ps
module rtc_sec_regs
  import rtc_sec_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_W = 2 * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              load_ack_i,
  input  logic              cap_ack_i,
  input  logic              clr_ack_i,
  input  logic [CNT_W-1:0]  cap_i,
  input  logic [STAT_W-1:0] stat_i,
  output ctrl_t             ctrl_o,
  output logic [CNT_W-1:0]  rate_o,
  output logic [CNT_W-1:0]  preset_o,
  output logic [CNT_W-1:0]  match_o,
  output logic [DATA_W-1:0] rdata_o
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] pair_w [NUM_PAIR];

  // bus write wins over the hardware acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_RST;
    end else if (wr_i && idx_i == IDX_CTRL) begin
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end else begin
      if (load_ack_i) ctrl_q.load <= 1'b0;
      if (cap_ack_i)  ctrl_q.cap  <= 1'b0;
      if (clr_ack_i)  ctrl_q.clr  <= 1'b0;
    end
  end

  for (genvar g = 0; g < NUM_PAIR; g++) begin : g_pair
    localparam logic [IDX_W-1:0] LO = IDX_W'(1 + 2 * g);
    localparam logic [IDX_W-1:0] HI = IDX_W'(2 + 2 * g);
    logic [CNT_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 q <= '0;
      else if (wr_i && idx_i == LO) q[DATA_W-1:0] <= wdata_i;
      else if (wr_i && idx_i == HI) q[CNT_W-1:DATA_W] <= wdata_i;
    end
    assign pair_w[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    case (idx_i)
      IDX_CTRL:     rdata_o = DATA_W'(ctrl_q);
      IDX_RATE_LO:  rdata_o = pair_w[0][DATA_W-1:0];
      IDX_RATE_HI:  rdata_o = pair_w[0][CNT_W-1:DATA_W];
      IDX_PRE_LO:   rdata_o = pair_w[1][DATA_W-1:0];
      IDX_PRE_HI:   rdata_o = pair_w[1][CNT_W-1:DATA_W];
      IDX_MATCH_LO: rdata_o = pair_w[2][DATA_W-1:0];
      IDX_MATCH_HI: rdata_o = pair_w[2][CNT_W-1:DATA_W];
      IDX_STAT:     rdata_o = DATA_W'(stat_i);
      IDX_CAP_LO:   rdata_o = cap_i[DATA_W-1:0];
      IDX_CAP_HI:   rdata_o = cap_i[CNT_W-1:DATA_W];
      default:      rdata_o = '0;
    endcase
  end

  assign ctrl_o   = ctrl_q;
  assign rate_o   = pair_w[0];
  assign preset_o = pair_w[1];
  assign match_o  = pair_w[2];
endmodule

// File: rtl/rtc_sec_prescaler.sv
`timescale 1ns/1ps
module rtc_sec_prescaler #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] rate_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] div_q;
  logic             run;

  assign run    = run_i && (rate_i != '0);
  // >= keeps a lowered rate word from stranding the divider above it
  assign tick_o = run && (div_q >= rate_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              div_q <= '0;
    else if (!run || tick_o)  div_q <= '0;
    else                      div_q <= div_q + CNT_W'(1);
  end
endmodule

// File: rtl/rtc_sec_counter.sv
`timescale 1ns/1ps
module rtc_sec_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_ni,
  input  logic             wrap_i,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  input  logic             cap_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] cnt_nxt_o,
  output logic             upd_o,
  output logic [CNT_W-1:0] cap_o,
  output logic             load_ack_o,
  output logic             cap_ack_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d, cap_q;

  always_comb begin
    cnt_d = cnt_q;
    if (!srst_ni)             cnt_d = '0;
    else if (load_i)          cnt_d = preset_i;
    else if (tick_i) begin
      if (cnt_q == CNT_MAX)   cnt_d = wrap_i ? '0 : CNT_MAX;
      else                    cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      cap_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      if (cap_i) cap_q <= cnt_q;
    end
  end

  assign cnt_o      = cnt_q;
  assign cnt_nxt_o  = cnt_d;
  assign upd_o      = srst_ni && (load_i || tick_i);
  assign cap_o      = cap_q;
  assign load_ack_o = load_i;
  assign cap_ack_o  = cap_i;
endmodule

// File: rtl/rtc_sec_alarm.sv
`timescale 1ns/1ps
module rtc_sec_alarm
  import rtc_sec_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              srst_ni,
  input  logic              upd_i,
  input  logic [CNT_W-1:0]  cnt_nxt_i,
  input  logic [CNT_W-1:0]  match_i,
  input  logic              clr_i,
  input  logic              mask_i,
  input  logic              frc_i,
  output logic              pend_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              irq_o,
  output logic              clr_ack_o
);
  logic pend_q, hit;

  assign hit = upd_i && (cnt_nxt_i == match_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (!srst_ni) pend_q <= 1'b0;
    else if (hit)      pend_q <= 1'b1;
    else if (clr_i)    pend_q <= 1'b0;
  end

  assign irq_o     = (pend_q && !mask_i) || frc_i;
  assign stat_o    = {irq_o, pend_q};
  assign pend_o    = pend_q;
  assign clr_ack_o = clr_i;
endmodule

// File: rtl/rtc_sec_timer.sv
`timescale 1ns/1ps
module rtc_sec_timer
  import rtc_sec_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned CNT_W = 2 * DATA_W;

  ctrl_t             ctrl;
  logic [CNT_W-1:0]  rate, preset, match, cnt, cnt_nxt, cap;
  logic [STAT_W-1:0] stat;
  logic              tick, upd, pend, load_ack, cap_ack, clr_ack;

  rtc_sec_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .idx_i     (addr_i),
    .wdata_i   (wdata_i),
    .load_ack_i(load_ack),
    .cap_ack_i (cap_ack),
    .clr_ack_i (clr_ack),
    .cap_i     (cap),
    .stat_i    (stat),
    .ctrl_o    (ctrl),
    .rate_o    (rate),
    .preset_o  (preset),
    .match_o   (match),
    .rdata_o   (rdata_o)
  );

  rtc_sec_prescaler #(.CNT_W(CNT_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (ctrl.srst_n && ctrl.cnt_en),
    .rate_i(rate),
    .tick_o(tick)
  );

  rtc_sec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .srst_ni   (ctrl.srst_n),
    .wrap_i    (ctrl.wrap),
    .tick_i    (tick),
    .load_i    (ctrl.load),
    .preset_i  (preset),
    .cap_i     (ctrl.cap),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .upd_o     (upd),
    .cap_o     (cap),
    .load_ack_o(load_ack),
    .cap_ack_o (cap_ack)
  );

  rtc_sec_alarm #(.CNT_W(CNT_W)) u_alm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .srst_ni  (ctrl.srst_n),
    .upd_i    (upd),
    .cnt_nxt_i(cnt_nxt),
    .match_i  (match),
    .clr_i    (ctrl.clr),
    .mask_i   (ctrl.mask),
    .frc_i    (ctrl.frc),
    .pend_o   (pend),
    .stat_o   (stat),
    .irq_o    (irq_o),
    .clr_ack_o(clr_ack)
  );
endmodule

// File: rtl/rtc_sec_timer_chk.sv
`timescale 1ns/1ps
module rtc_sec_timer_chk
  import rtc_sec_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input ctrl_t            ctrl_i,
  input logic [CNT_W-1:0] preset_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic             tick_i,
  input logic             pend_i,
  input logic             irq_i
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  // R3
  tick_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (ctrl_i.cnt_en && ctrl_i.srst_n));

  // R4
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ctrl_i.load && ctrl_i.srst_n) |=> $stable(cnt_i));

  // R5
  load_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.load && ctrl_i.srst_n) |=> (cnt_i == $past(preset_i)));

  // R5
  load_selfclr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.load && !wr_i) |=> !ctrl_i.load);

  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && cnt_i == CNT_MAX && !ctrl_i.wrap && !ctrl_i.load && ctrl_i.srst_n)
      |=> (cnt_i == CNT_MAX));

  // R9
  force_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_i.frc |-> irq_i);

  // R9
  mask_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_i.mask && !ctrl_i.frc) |-> !irq_i);

  // R11
  soft_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_i.srst_n |=> (cnt_i == '0 && !pend_i));
endmodule

bind rtc_sec_timer rtc_sec_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .wr_i    (wr_i),
  .ctrl_i  (ctrl),
  .preset_i(preset),
  .cnt_i   (cnt),
  .tick_i  (tick),
  .pend_i  (pend),
  .irq_i   (irq_o)
);

// File: tb/rtc_sec_timer_test.sv
`timescale 1ns/1ps
module rtc_sec_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  rtc_sec_timer uut (
    .clk_i  (clk),
    .rst_ni (rst_n),
    .wr_i   (we),
    .addr_i (addr),
    .wdata_i(wdata),
    .rdata_o(rdata),
    .irq_o  (irq)
  );

  // behavioural reference
  bit [7:0]  m_ctrl;
  bit [31:0] m_rate, m_pre, m_match, m_cap, m_cnt, m_div, nc;
  bit        m_pend, run, tick, upd;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 8'h21; m_rate = 0; m_pre = 0; m_match = 0;
      m_cap = 0; m_cnt = 0; m_div = 0; m_pend = 0;
    end else begin
      run  = m_ctrl[0] && m_ctrl[1] && (m_rate != 0);
      tick = run && (m_div >= m_rate - 1);
      nc = m_cnt;
      if (!m_ctrl[0]) nc = 0;
      else if (m_ctrl[3]) nc = m_pre;
      else if (tick) nc = (m_cnt == 32'hFFFF_FFFF) ? (m_ctrl[2] ? 32'd0 : m_cnt) : m_cnt + 1;
      upd = m_ctrl[0] && (m_ctrl[3] || tick);
      if (m_ctrl[4]) m_cap = m_cnt;
      if (!m_ctrl[0]) m_pend = 0;
      else if (upd && nc == m_match) m_pend = 1;
      else if (m_ctrl[7]) m_pend = 0;
      m_div = (!run || tick) ? 32'd0 : m_div + 1;
      m_cnt = nc;
      m_ctrl[3] = 0; m_ctrl[4] = 0; m_ctrl[7] = 0;
      if (we) begin
        case (addr)
          4'd0: m_ctrl = wdata[7:0];
          4'd1: m_rate[15:0] = wdata;
          4'd2: m_rate[31:16] = wdata;
          4'd3: m_pre[15:0] = wdata;
          4'd4: m_pre[31:16] = wdata;
          4'd5: m_match[15:0] = wdata;
          4'd6: m_match[31:16] = wdata;
          default: ;
        endcase
      end
    end
  end

  function automatic bit m_irq();
    return (m_pend && !m_ctrl[5]) || m_ctrl[6];
  endfunction

  function automatic bit [15:0] m_read(input logic [3:0] a);
    case (a)
      4'd0: return {8'h00, m_ctrl};
      4'd1: return m_rate[15:0];
      4'd2: return m_rate[31:16];
      4'd3: return m_pre[15:0];
      4'd4: return m_pre[31:16];
      4'd5: return m_match[15:0];
      4'd6: return m_match[31:16];
      4'd7: return {14'd0, m_irq(), m_pend};
      4'd8: return m_cap[15:0];
      4'd9: return m_cap[31:16];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R9 model rdata", {16'd0, rdata}, {16'd0, m_read(addr)});
      chk("R9 model irq", {31'd0, irq}, {31'd0, m_irq()});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog all-requirements act=%0d exp<=100000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] off, input logic [15:0] d);
    addr = off[5:2]; wdata = d; we = 1'b1;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input string tag, input logic [7:0] off, input logic [15:0] exp);
    addr = off[5:2];
    @(negedge clk);
    chk(tag, {16'd0, rdata}, {16'd0, exp});
    @(posedge clk); #1;
  endtask

  task automatic irqc(input string tag, input logic exp);
    @(negedge clk);
    chk(tag, {31'd0, irq}, {31'd0, exp});
    @(posedge clk); #1;
  endtask

  task automatic run_n(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic capture(input logic [15:0] c);
    wr(8'h00, c | 16'h0010);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R1 reset state
    rd("R1 ctrl", 8'h00, 16'h0021);
    rd("R1 rate_lo", 8'h04, 16'h0000);
    rd("R1 status", 8'h1C, 16'h0000);
    rd("R1 cap_hi", 8'h24, 16'h0000);
    irqc("R1 irq", 1'b0);

    // R2 register access
    wr(8'h04, 16'h0004); wr(8'h08, 16'h0000);
    wr(8'h0C, 16'h0005); wr(8'h10, 16'h0001);
    wr(8'h14, 16'h0009); wr(8'h18, 16'h0001);
    rd("R2 rate_lo", 8'h04, 16'h0004);
    rd("R2 preset_lo", 8'h0C, 16'h0005);
    rd("R2 preset_hi", 8'h10, 16'h0001);
    rd("R2 match_lo", 8'h14, 16'h0009);
    wr(8'h1C, 16'hFFFF);
    rd("R2 status ro", 8'h1C, 16'h0000);
    wr(8'h20, 16'h1234);
    rd("R2 cap ro", 8'h20, 16'h0000);
    rd("R2 unmapped 0x28", 8'h28, 16'h0000);
    rd("R2 unmapped 0x3C", 8'h3C, 16'h0000);

    // R5 load handshake
    wr(8'h00, 16'h0029);
    rd("R5 load bit pending", 8'h00, 16'h0029);
    rd("R5 load bit cleared", 8'h00, 16'h0021);

    // R6 capture handshake
    wr(8'h00, 16'h0031);
    rd("R6 cap bit pending", 8'h00, 16'h0031);
    rd("R6 cap lo", 8'h20, 16'h0005);
    rd("R6 cap hi", 8'h24, 16'h0001);
    rd("R6 cap bit cleared", 8'h00, 16'h0021);

    // R3 one tick per rate-word cycles
    wr(8'h00, 16'h0023);
    run_n(7);
    wr(8'h00, 16'h0021);
    capture(16'h0021);
    rd("R3 two ticks in eight cycles", 8'h20, 16'h0007);

    // R3 rate word zero halts
    wr(8'h04, 16'h0000);
    wr(8'h00, 16'h0023);
    run_n(20);
    wr(8'h00, 16'h0021);
    capture(16'h0021);
    rd("R3 zero rate halts", 8'h20, 16'h0007);
    wr(8'h04, 16'h0004);

    // R4 disabled count holds, prescaler restarts
    wr(8'h00, 16'h0023);
    wr(8'h00, 16'h0021);
    run_n(10);
    capture(16'h0021);
    rd("R4 hold while disabled", 8'h20, 16'h0007);
    wr(8'h00, 16'h0023);
    run_n(7);
    wr(8'h00, 16'h0021);
    capture(16'h0021);
    rd("R4 full period after restart", 8'h20, 16'h0009);

    // clear alarm raised at 0x10009 while masked
    wr(8'h00, 16'h00A1);
    @(posedge clk); #1;
    rd("R10 clear masked alarm", 8'h1C, 16'h0000);

    // R7 wrap
    wr(8'h0C, 16'hFFFE); wr(8'h10, 16'hFFFF);
    wr(8'h00, 16'h002D);
    wr(8'h00, 16'h0027);
    run_n(7);
    wr(8'h00, 16'h0025);
    capture(16'h0025);
    rd("R7 wrap lo", 8'h20, 16'h0000);
    rd("R7 wrap hi", 8'h24, 16'h0000);

    // R7 saturate
    wr(8'h00, 16'h0029);
    wr(8'h00, 16'h0023);
    run_n(11);
    wr(8'h00, 16'h0021);
    capture(16'h0021);
    rd("R7 saturate lo", 8'h20, 16'hFFFF);
    rd("R7 saturate hi", 8'h24, 16'hFFFF);

    // R8 alarm by tick, R9 masking and force
    wr(8'h0C, 16'h0100); wr(8'h10, 16'h0000);
    wr(8'h14, 16'h0102); wr(8'h18, 16'h0000);
    wr(8'h00, 16'h0029);
    wr(8'h00, 16'h0023);
    run_n(7);
    wr(8'h00, 16'h0021);
    rd("R8 raw set by tick", 8'h1C, 16'h0001);
    irqc("R9 masked irq low", 1'b0);
    wr(8'h00, 16'h0001);
    irqc("R9 unmasked irq high", 1'b1);
    rd("R9 status unmasked", 8'h1C, 16'h0003);
    wr(8'h00, 16'h0021);
    wr(8'h00, 16'h0061);
    irqc("R9 force irq", 1'b1);
    rd("R9 status forced", 8'h1C, 16'h0003);
    wr(8'h00, 16'h0001);

    // R10 self-clearing clear
    wr(8'h00, 16'h0081);
    rd("R10 clr bit pending", 8'h00, 16'h0081);
    rd("R10 raw cleared", 8'h1C, 16'h0000);
    irqc("R10 irq dropped", 1'b0);
    rd("R10 clr bit cleared", 8'h00, 16'h0001);

    // R8 alarm by preset copy, and set beats clear
    wr(8'h0C, 16'h0102);
    wr(8'h00, 16'h0009);
    @(posedge clk); #1;
    rd("R8 raw set by load", 8'h1C, 16'h0003);
    wr(8'h00, 16'h0081);
    @(posedge clk); #1;
    rd("R10 cleared again", 8'h1C, 16'h0000);
    wr(8'h00, 16'h0089);
    @(posedge clk); #1;
    rd("R10 set wins over clear", 8'h1C, 16'h0003);
    irqc("R10 irq after set wins", 1'b1);

    // R11 soft reset
    wr(8'h00, 16'h0000);
    @(posedge clk); #1;
    rd("R11 raw cleared", 8'h1C, 16'h0000);
    irqc("R11 irq low", 1'b0);
    capture(16'h0000);
    rd("R11 count zero lo", 8'h20, 16'h0000);
    rd("R11 count zero hi", 8'h24, 16'h0000);
    rd("R11 rate kept", 8'h04, 16'h0004);
    rd("R11 match kept", 8'h14, 16'h0102);
    wr(8'h00, 16'h0002);
    run_n(12);
    capture(16'h0002);
    rd("R11 no count in soft reset", 8'h20, 16'h0000);
    wr(8'h00, 16'h0021);
    run_n(3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule